// File: doc/BRIEF.md
# Impedance Update Request Filter

This block decides when a new output-driver impedance code takes effect. A comparator elsewhere issues periodic update requests, each carrying a candidate code. The filter applies a candidate only once the same code has arrived in a programmable number of back-to-back requests. This keeps a noisy comparator from making the pads toggle between neighbouring codes. A lock input freezes the applied code. A rising edge on the retrain input starts a new calibration, and the next request after it is taken unconditionally.

The accepted code passes through a signed drive-strength trim and then a per-side force trim, so that the pull-up and pull-down drivers each get their own final code. Every trim saturates at the ends of the code range. Update requests arrive on a valid/ready stream. The block never applies back-pressure: `req_ready` is held high, and a request is consumed in every cycle where `req_valid` is high. Requests that arrive while locked, or in the same cycle as a retrain edge, are consumed and then discarded. All other inputs are plain levels that are sampled on every clock.

Top module: `imp_upd_filter`

## Requirements
- R1: When `filt_sel` is 3'b000, each consumed request (unless locked or coinciding with a retrain edge) becomes the accepted code at the next clock edge.
- R2: When `filt_sel` is k in 1..7, a request's code is applied once it is the (k+1)-th consecutive request carrying that same code. A request with a different code restarts the run at 1. The run counter saturates at 8.
- R3: Cycles without a valid request neither break nor advance a run; only consumed requests count.
- R4: While `lock` is high, requests are discarded: the accepted code, the run count and the stored candidate all stay unchanged.
- R5: A 0-to-1 transition of `retrain` clears the run, and the next consumed unlocked request is then applied regardless of `filt_sel`. A request in the edge cycle is discarded. Holding `retrain` high has no further effect.
- R6: `code_out` equals the accepted code plus (3 − `drive_sel`) code steps, where 3'b011 means nominal and 3'b000 means +3. The result saturates at 0 and 2^CODE_W−1.
- R7: `pu_code` is `code_out` + `pu_up` − `pu_dn`, and `pd_code` is `code_out` + `pd_up` − `pd_dn`, each saturated. These act independently of the filter, and when both bits are set they cancel.
- R8: After reset the accepted code is RESET_CODE, the run count is 0 and no unconditional acceptance is pending.
- R9: `req_ready` is 1 in every cycle, so a request is consumed whenever `req_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Always 1 |
| req_code | input | CODE_W | Candidate impedance code |
| filt_sel | input | 3 | Run length select (000 = bypass) |
| lock | input | 1 | Freeze applied code |
| retrain | input | 1 | Rising edge restarts calibration |
| drive_sel | input | 3 | Drive-strength offset select |
| pu_up | input | 1 | Pull-up side one step stronger |
| pu_dn | input | 1 | Pull-up side one step weaker |
| pd_up | input | 1 | Pull-down side one step stronger |
| pd_dn | input | 1 | Pull-down side one step weaker |
| code_out | output | CODE_W | Accepted code after drive offset |
| pu_code | output | CODE_W | Final pull-up code |
| pd_code | output | CODE_W | Final pull-down code |

## Verification
The bench builds the block with CODE_W=5 and RESET_CODE=16. With these values both saturation ends are only a few steps away from the codes a sweep of `drive_sel` and the force bits produces, so clamping at 0 and at 31 is exercised. The bench sweeps all eight `filt_sel` values against runs that are one short of, exactly at, and longer than the required length, with idle gaps inside the runs. It also covers locking in the middle of a run and holding `retrain` high across several requests.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  localparam int unsigned RUN_MAX = 8;
  localparam int unsigned RUN_W   = 4;

  // Requests needed before a code is applied for a filter select value.
  function automatic logic [RUN_W-1:0] run_need(input logic [2:0] sel);
    if (sel == 3'b000) return RUN_W'(1);
    return {1'b0, sel} + RUN_W'(1);
  endfunction

  // Signed step (4-bit two's complement) for a drive select value: 3 - sel.
  function automatic logic [3:0] drive_step(input logic [2:0] sel);
    return 4'd3 - {1'b0, sel};
  endfunction

  // Signed step for a pair of force bits.
  function automatic logic [3:0] force_step(input logic up, input logic dn);
    if (up && !dn) return 4'b0001;
    if (dn && !up) return 4'b1111;
    return 4'b0000;
  endfunction
endpackage

// File: rtl/ifl_edge_detect.sv
module ifl_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;

  // R5: a held level yields one edge only
  assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rise) |-> !rise);
endmodule

// File: rtl/ifl_trim.sv
module ifl_trim #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] base,
  input  logic [3:0]   step,
  output logic [W-1:0] res
);
  localparam int unsigned SW = W + 2;
  logic [SW-1:0] sum;

  always_comb begin
    sum = {2'b00, base} + {{(SW-4){step[3]}}, step};
    if (sum[SW-1])      res = '0;
    else if (sum[SW-2]) res = '1;
    else                res = sum[W-1:0];
  end
endmodule

// File: rtl/ifl_run_filter.sv
module ifl_run_filter
  import ifl_pkg::*;
#(
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned RESET_CODE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [CODE_W-1:0] code,
  input  logic [2:0]        filt_sel,
  input  logic              lock,
  input  logic              rtr_edge,
  output logic [CODE_W-1:0] acc_code
);
  logic [CODE_W-1:0] cand_q;
  logic [RUN_W-1:0]  run_q, run_nxt, need;
  logic              fresh_q, take, match, apply;

  assign need    = run_need(filt_sel);
  assign take    = xfer & ~lock & ~rtr_edge;
  assign match   = (run_q != '0) && (code == cand_q);
  assign run_nxt = !match ? RUN_W'(1) :
                   (run_q == RUN_W'(RUN_MAX)) ? run_q : run_q + RUN_W'(1);
  assign apply   = take & (fresh_q | (run_nxt >= need));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q   <= '0;
      run_q    <= '0;
      fresh_q  <= 1'b0;
      acc_code <= CODE_W'(RESET_CODE);
    end else if (rtr_edge) begin
      run_q   <= '0;
      fresh_q <= 1'b1;
    end else if (take) begin
      cand_q <= code;
      run_q  <= run_nxt;
      if (apply) begin
        acc_code <= code;
        fresh_q  <= 1'b0;
      end
    end
  end

  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !lock && !rtr_edge && filt_sel == 3'b000) |=> acc_code == $past(code));
  assert_change_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_code) |-> $past(xfer && !lock));
  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(acc_code));
  assert_edge_no_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rtr_edge |=> $stable(acc_code));
endmodule

// File: rtl/imp_upd_filter.sv
module imp_upd_filter
  import ifl_pkg::*;
#(
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned RESET_CODE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic [2:0]        filt_sel,
  input  logic              lock,
  input  logic              retrain,
  input  logic [2:0]        drive_sel,
  input  logic              pu_up,
  input  logic              pu_dn,
  input  logic              pd_up,
  input  logic              pd_dn,
  output logic [CODE_W-1:0] code_out,
  output logic [CODE_W-1:0] pu_code,
  output logic [CODE_W-1:0] pd_code
);
  localparam int unsigned SIDES = 2;

  logic              rtr_edge;
  logic [CODE_W-1:0] acc_code;
  logic [SIDES-1:0]  f_up, f_dn;
  logic [CODE_W-1:0] side_code [SIDES];

  assign req_ready = 1'b1;

  ifl_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(retrain), .rise(rtr_edge)
  );

  ifl_run_filter #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_filt (
    .clk(clk), .rst_n(rst_n), .xfer(req_valid & req_ready), .code(req_code),
    .filt_sel(filt_sel), .lock(lock), .rtr_edge(rtr_edge), .acc_code(acc_code)
  );

  ifl_trim #(.W(CODE_W)) u_drive (
    .base(acc_code), .step(drive_step(drive_sel)), .res(code_out)
  );

  assign f_up = {pd_up, pu_up};
  assign f_dn = {pd_dn, pu_dn};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    ifl_trim #(.W(CODE_W)) u_force (
      .base(code_out), .step(force_step(f_up[s], f_dn[s])), .res(side_code[s])
    );
  end

  assign pu_code = side_code[0];
  assign pd_code = side_code[1];

  assert_nominal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_sel == 3'b011 |-> code_out == acc_code);
  assert_pu_balance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pu_up == pu_dn |-> pu_code == code_out);
  assert_pd_balance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_up == pd_dn |-> pd_code == code_out);
  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
endmodule

// File: tb/sim_imp_upd_filter.sv
module sim_imp_upd_filter;
  localparam int CW   = 5;
  localparam int RSTC = 16;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, lock = 0, retrain = 0;
  logic [CW-1:0] req_code = '0;
  logic [2:0] filt_sel = 3'b010, drive_sel = 3'b011;
  logic pu_up = 0, pu_dn = 0, pd_up = 0, pd_dn = 0;
  logic req_ready;
  logic [CW-1:0] code_out, pu_code, pd_code;

  int errors = 0, checks = 0;
  string cur_req = "R8";

  always #10 clk = ~clk;

  imp_upd_filter #(.CODE_W(CW), .RESET_CODE(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .filt_sel(filt_sel), .lock(lock), .retrain(retrain),
    .drive_sel(drive_sel), .pu_up(pu_up), .pu_dn(pu_dn), .pd_up(pd_up),
    .pd_dn(pd_dn), .code_out(code_out), .pu_code(pu_code), .pd_code(pd_code)
  );

  // Behavioural reference model
  int m_acc = RSTC, m_cand = 0, m_run = 0;
  bit m_fresh = 0, m_rprev = 0;

  function automatic int clampc(int v);
    if (v < 0) return 0;
    if (v > MAXC) return MAXC;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = RSTC; m_cand = 0; m_run = 0; m_fresh = 0; m_rprev = 0;
    end else begin
      bit edge_s;
      int need;
      edge_s  = retrain && !m_rprev;
      m_rprev = retrain;
      need = (filt_sel == 0) ? 1 : int'(filt_sel) + 1;
      if (edge_s) begin
        m_run = 0; m_fresh = 1;
      end else if (req_valid && !lock) begin
        if (m_run > 0 && int'(req_code) == m_cand) m_run = (m_run < 8) ? m_run + 1 : 8;
        else m_run = 1;
        m_cand = int'(req_code);
        if (m_fresh || m_run >= need) begin
          m_acc = int'(req_code); m_fresh = 0;
        end
      end
    end
  end

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int o;
      o = clampc(m_acc + 3 - int'(drive_sel));
      check(cur_req, int'(code_out), o);
      check({cur_req, "/R7 pu"}, int'(pu_code), clampc(o + int'(pu_up) - int'(pu_dn)));
      check({cur_req, "/R7 pd"}, int'(pd_code), clampc(o + int'(pd_up) - int'(pd_dn)));
      check("R9 ready", int'(req_ready), 1);
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic send(int c);
    req_valid = 1; req_code = CW'(c);
    step();
    req_valid = 0;
  endtask

  task automatic pulse_retrain();
    retrain = 1; step(); retrain = 0; step();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1; #1;
    check("R8 reset code", int'(code_out), RSTC);
    step();

    // R1 / R2 sweep with runs short, exact and long, plus mismatches
    for (int f = 0; f < 8; f++) begin
      filt_sel = 3'(f);
      cur_req = (f == 0) ? "R1" : "R2";
      pulse_retrain();
      send(3);
      for (int n = 0; n < f; n++) send(9);     // one short of run
      send(4);                                  // break
      for (int n = 0; n < f + 1; n++) send(9);  // exact run
      for (int n = 0; n < f + 2; n++) begin send(11); send(12); end
      for (int n = 0; n < 10; n++) send(20);    // saturating run
    end

    // R3 gaps inside a run
    cur_req = "R3"; filt_sel = 3'b011;
    for (int n = 0; n < 5; n++) begin send(7); step(); step(); end
    send(8); step(); send(8); step(); step(); send(8); send(8); step();

    // R4 lock mid-run
    cur_req = "R4"; filt_sel = 3'b010;
    send(14); lock = 1;
    for (int n = 0; n < 6; n++) send(25);
    send(14); lock = 0; send(14); send(14); send(14);

    // R5 retrain held high, request on the edge discarded
    cur_req = "R5"; filt_sel = 3'b111;
    retrain = 1; send(2);
    for (int n = 0; n < 4; n++) send(30 - n);
    retrain = 0; send(5); send(6);
    retrain = 1; lock = 1; send(1); lock = 0; retrain = 0; send(27); send(28);

    // R6 drive offsets with saturation
    cur_req = "R6"; filt_sel = 3'b000;
    for (int d = 0; d < 8; d++) begin
      drive_sel = 3'(d);
      send(0); send(1); send(MAXC); send(MAXC - 2); send(16);
    end

    // R7 force bits
    cur_req = "R7"; drive_sel = 3'b011;
    for (int k = 0; k < 16; k++) begin
      {pu_up, pu_dn, pd_up, pd_dn} = 4'(k);
      send(0); send(MAXC); send(10);
    end
    {pu_up, pu_dn, pd_up, pd_dn} = 4'b0;
    step(); step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule